// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small processor core. It latches interrupt requests from a set of peripheral sources into pending bits, gates each pending bit with a per-source enable and a single global enable flag, and picks the winner by fixed priority. The winner is the source with the lowest vector address. The block presents the winner's program-memory word address to the core together with a valid flag.

A reset condition forms its own vector at address zero. It outranks every source and ignores both kinds of enable. Any of four reset causes raises it: external pin, power-on, brown-out or watchdog. The controller also comes out of its own reset with this vector pending. Each source takes a slot two words above the one before it, so source bit k jumps to word address 2*(k+1).

When the core accepts the presented vector it pulses the acknowledge input. The controller then drops the serviced pending bit and clears the global enable, which blocks nesting. A return strobe from the interrupt handler sets the global enable again. Software can also write the flag directly.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset no source is pending, the global enable `gie` reads 0, and the reset vector is presented (`vec_valid`=1, `vec_addr`=0).
- R2: Any bit of `rst_cause` (bit 0 pin, 1 power-on, 2 brown-out, 3 watchdog) makes the reset vector pending from the next cycle. It then wins over every source, whatever the state of `gie` and `en_mask`.
- R3: A pending source bit k is serviceable only while both `en_mask[k]` and `gie` are 1.
- R4: The vector for source bit k is word address 2*(k+1), and the reset vector is address 0.
- R5: Among the serviceable sources, the one with the lowest bit index is presented.
- R6: When nothing is serviceable and reset is not pending, `vec_valid` is 0 and `vec_addr` is 0.
- R7: `irq_ack` while `vec_valid`=1 clears the presented pending bit (or the reset vector) and clears `gie` from the next cycle. `irq_ack` while `vec_valid`=0 has no effect.
- R8: `gie` is updated by three inputs in fixed precedence: a taken acknowledge clears it, otherwise `irq_ret` sets it, otherwise `gie_we` loads `gie_din`.
- R9: A `src_req` pulse on the same cycle as the acknowledge that clears that source leaves the source pending.
- R10: A request stays pending while it is masked, and it is presented as soon as it becomes serviceable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_cause | input | 4 | Reset-cause strobes: pin, power-on, brown-out, watchdog |
| src_req | input | NUM_SRC (17) | One-cycle request pulses that set the pending bits |
| en_mask | input | NUM_SRC (17) | Per-source enable bits |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_din | input | 1 | Value written to the global enable |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Return-from-handler strobe |
| gie | output | 1 | Current global enable flag |
| vec_valid | output | 1 | A vector is being presented |
| vec_addr | output | ADDR_W (6) | Program word address of the presented vector |

## Verification
The bench builds one instance with NUM_SRC=5. That size lets it sweep every pending pattern against every enable mask with the global flag both set and cleared, and compare the winner with a lowest-set-bit computation. A second instance keeps the default of 17 sources and checks the top slot at address 34 against a simultaneous request on bit 0. Directed sequences on the small instance cover the enable precedence, ignored acknowledges, and a request that coincides with its own clear.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NUM_RST_CAUSES = 4;
    localparam int SLOT_STRIDE    = 2;

    // Word address of a vector slot; slot 0 is the reset vector.
    function automatic int unsigned slot_word_addr(input int unsigned slot);
        return slot * SLOT_STRIDE;
    endfunction
endpackage

// File: rtl/vic_qual.sv
module vic_qual #(
    parameter int NUM_SRC = 17
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               gie,
    output logic [NUM_SRC-1:0] qual
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        assign qual[i] = pend[i] & mask[i] & gie;
    end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int NUM_SRC = 17,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] grant
);
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any   = 1'b1;
                idx   = IDX_W'(i);
                grant = NUM_SRC'(1) << i;
            end
        end
    end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 17,
    localparam int ADDR_W = $clog2(SLOT_STRIDE * NUM_SRC + 1),
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_RST_CAUSES-1:0] rst_cause,
    input  logic [NUM_SRC-1:0]        src_req,
    input  logic [NUM_SRC-1:0]        en_mask,
    input  logic                      gie_we,
    input  logic                      gie_din,
    input  logic                      irq_ack,
    input  logic                      irq_ret,
    output logic                      gie,
    output logic                      vec_valid,
    output logic [ADDR_W-1:0]         vec_addr
);
    typedef struct packed {
        logic               rst_pend;
        logic               gie;
        logic [NUM_SRC-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] qual;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic               take;
    logic [NUM_SRC-1:0] clr;

    vic_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .pend (st_q.pend),
        .mask (en_mask),
        .gie  (st_q.gie),
        .qual (qual)
    );

    vic_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .req   (qual),
        .any   (win_any),
        .idx   (win_idx),
        .grant (grant)
    );

    always_comb begin
        st_d      = st_q;
        vec_valid = st_q.rst_pend | win_any;
        vec_addr  = '0;
        if (!st_q.rst_pend && win_any) begin
            vec_addr = ADDR_W'(slot_word_addr(int'(win_idx) + 1));
        end

        take = irq_ack & vec_valid;
        clr  = (take && !st_q.rst_pend) ? grant : '0;

        st_d.rst_pend = (st_q.rst_pend & ~take) | (|rst_cause);
        st_d.pend     = (st_q.pend & ~clr) | src_req;

        if (take) begin
            st_d.gie = 1'b0;
        end else if (irq_ret) begin
            st_d.gie = 1'b1;
        end else if (gie_we) begin
            st_d.gie = gie_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rst_pend: 1'b1, gie: 1'b0, pend: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign gie = st_q.gie;
endmodule

// File: rtl/vic_irq_chk.sv
module vic_irq_chk #(
    parameter int NUM_SRC = 17,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         rst_cause,
    input logic [NUM_SRC-1:0] en_mask,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               gie,
    input logic               vec_valid,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic               rst_pend
);
    logic slot_enabled;
    always_comb begin
        slot_enabled = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (vec_addr == ADDR_W'(2 * (i + 1))) slot_enabled = en_mask[i];
        end
    end

    p_cause_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_cause) |=> rst_pend);

    p_reset_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |-> (vec_valid && vec_addr == '0));

    p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !rst_pend) |-> (gie && slot_enabled));

    p_even_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[0] == 1'b0);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_addr == '0);

    p_ack_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && vec_valid) |=> !gie);

    p_ret_sets_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_ack && vec_valid)) |=> gie);
endmodule

bind vic_irq_ctrl vic_irq_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_cause (rst_cause),
    .en_mask   (en_mask),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .gie       (gie),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .rst_pend  (st_q.rst_pend)
);

// File: tb/vic_irq_ctrl_tb.sv
module vic_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 5;
    localparam int AW = $clog2(2 * N + 1);
    localparam int NF = 17;
    localparam int AWF = $clog2(2 * NF + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [3:0]   rst_cause = '0;
    logic [N-1:0] src_req = '0, en_mask = '0;
    logic gie_we = 0, gie_din = 0, irq_ack = 0, irq_ret = 0;
    logic gie, vec_valid;
    logic [AW-1:0] vec_addr;

    logic [3:0]    f_cause = '0;
    logic [NF-1:0] f_req = '0, f_mask = '0;
    logic f_we = 0, f_din = 0, f_ack = 0, f_ret = 0;
    logic f_gie, f_valid;
    logic [AWF-1:0] f_addr;

    vic_irq_ctrl #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .src_req(src_req),
        .en_mask(en_mask), .gie_we(gie_we), .gie_din(gie_din), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .gie(gie), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    vic_irq_ctrl #(.NUM_SRC(NF)) u_full (
        .clk(clk), .rst_n(rst_n), .rst_cause(f_cause), .src_req(f_req),
        .en_mask(f_mask), .gie_we(f_we), .gie_din(f_din), .irq_ack(f_ack),
        .irq_ret(f_ret), .gie(f_gie), .vec_valid(f_valid), .vec_addr(f_addr)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Clear every pending item and leave gie = 1.
    task automatic drain();
        en_mask = '1;
        for (int i = 0; i < N + 2; i++) begin
            step();
            irq_ret = 0;
            irq_ack = vec_valid;
            step();
            irq_ack = 0;
            irq_ret = 1;
        end
        step();
        irq_ret = 0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check("R1 valid", vec_valid, 1);
        check("R1 addr", vec_addr, 0);
        check("R1 gie", gie, 0);

        // R3 R4 R5 R6: sweep pending x mask x gie
        for (int p = 0; p < (1 << N); p++) begin
            for (int m = 0; m < (1 << N); m++) begin
                for (int g = 0; g < 2; g++) begin
                    int q, lo, ea, ev;
                    drain();
                    src_req = N'(p); en_mask = N'(m); gie_we = 1; gie_din = g[0];
                    step();
                    src_req = '0; gie_we = 0;
                    q = (g == 1) ? (p & m) : 0;
                    lo = -1;
                    for (int b = N - 1; b >= 0; b--) if (q[b]) lo = b;
                    ev = (lo >= 0) ? 1 : 0;
                    ea = (lo >= 0) ? 2 * (lo + 1) : 0;
                    check("R3/R5 sweep valid", vec_valid, ev);
                    check("R4/R6 sweep addr", vec_addr, ea);
                end
            end
        end

        // R2: reset cause outranks a source
        drain();
        src_req = 1; step(); src_req = 0;
        check("R4 addr bit0", vec_addr, 2);
        rst_cause = 4'b0100; step(); rst_cause = 0;
        check("R2 reset wins", vec_addr, 0);
        check("R2 reset valid", vec_valid, 1);
        irq_ack = 1; step(); irq_ack = 0;
        check("R7 ack clears gie", gie, 0);
        check("R7 gated after ack", vec_valid, 0);
        irq_ret = 1; step(); irq_ret = 0;
        check("R8 ret sets gie", gie, 1);
        check("R7 source still pending", vec_addr, 2);
        // R8: ack beats ret
        irq_ack = 1; irq_ret = 1; step(); irq_ack = 0; irq_ret = 0;
        check("R8 ack over ret", gie, 0);
        irq_ret = 1; step(); irq_ret = 0;
        check("R7 pending cleared", vec_valid, 0);
        // R7: ack with nothing valid is ignored
        irq_ack = 1; step(); irq_ack = 0;
        check("R7 idle ack ignored", gie, 1);
        // R2: cause bypasses gie = 0 and mask = 0
        gie_we = 1; gie_din = 0; en_mask = '0; rst_cause = 4'b1000; step();
        gie_we = 0; rst_cause = 0;
        check("R2 bypass", vec_valid, 1);
        check("R2 bypass addr", vec_addr, 0);

        // R9: set coincides with clear
        drain();
        src_req = 5'b00011; step(); src_req = 0;
        check("R9 first", vec_addr, 2);
        irq_ack = 1; src_req = 5'b00001; step(); irq_ack = 0; src_req = 0;
        irq_ret = 1; step(); irq_ret = 0;
        check("R9 re-pended", vec_addr, 2);

        // R10: masked request persists
        drain();
        en_mask = '0; src_req = 5'b01000; step(); src_req = 0;
        check("R10 masked", vec_valid, 0);
        en_mask = 5'b01000; step();
        check("R10 unmasked", vec_addr, 8);
        gie_we = 1; gie_din = 0; step(); gie_we = 0;
        check("R3 gie low blocks", vec_valid, 0);
        gie_we = 1; gie_din = 0; irq_ret = 1; step(); gie_we = 0; irq_ret = 0;
        check("R8 ret over write", gie, 1);

        // R4 R5: default-size instance
        f_ack = 1; step(); f_ack = 0;
        f_req = NF'(1) << (NF - 1); f_mask = '1; f_we = 1; f_din = 1; step();
        f_req = '0; f_we = 0;
        check("R4 top slot", f_addr, 2 * NF);
        f_req = NF'(1); step(); f_req = '0;
        check("R5 bit0 beats top", f_addr, 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule